// File: doc/BRIEF.md
# Memory-to-Memory Sequential Processor

This block is a small non-pipelined processor with no register file. Every operand lives in data memory. An instruction names two data addresses. Arithmetic results go back to the second of those two addresses. Instructions come from their own memory, which is separate from the data memory. Each instruction goes through six steps, one clock each: instruction read, decode, operand read, execute, result write, next-address update. A phase output shows which step is active.

Both memories are internal arrays. A load port fills them while the core is held in reset. After a halt, a one-port peek path reads back data memory. Control comes from a halt opcode that stops the core and raises `done`. The only other control is a conditional jump on equal operands.

Top module: `m2m_core`

## Requirements
- R1: While `rst` is high, on every rising edge the core returns to phase 0 with the program counter at `BOOT_PC` (default 0) and `done` low.
- R2: Outside halt, the phase output steps through 0,1,2,3,4,5 (instruction read, decode, operand read, execute, result write, address update), one clock per step, then returns to 0.
- R3: An instruction word has the opcode in bits 31:24, the first data address in 23:16, the second (destination) data address in 15:8 and a jump target in 7:0. Opcode 0x7A stores (data[first] + data[second]) mod 256 into data[second].
- R4: Opcode 0x7B stores (data[first] - data[second]) mod 256 into data[second].
- R5: Opcode 0x7C writes no data. The next program counter is the target field when data[first] equals data[second], and the program counter plus one otherwise.
- R6: The program counter changes only at the end of phase 5. For add, subtract and any unlisted opcode it advances by one, wrapping at its width.
- R7: An opcode other than 0x00, 0x7A, 0x7B or 0x7C leaves data memory unchanged. The target byte is ignored for every opcode except 0x7C.
- R8: Opcode 0x00 raises `done`, sets the phase to 6 and freezes the program counter at the halt's own address. This state holds until reset.
- R9: With `ld_en` high, `ld_imem` high writes the 32-bit `ld_data` to instruction memory at `ld_addr`. `ld_imem` low writes `ld_data[7:0]` to data memory.
- R10: While `done` is high, `peek_data` shows data[`peek_addr`] one rising edge after `peek_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe |
| ld_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| ld_addr | input | LAW (8) | Load address |
| ld_data | input | 32 | Load value (low byte for data memory) |
| peek_addr | input | DAW (8) | Data address read after halt |
| peek_data | output | DW (8) | Registered data read after halt |
| pc_o | output | IAW (8) | Program counter |
| phase_o | output | 3 | Current step, 6 when halted |
| done | output | 1 | Halt reached |

## Verification
On every cycle, assertions check these properties:
- The phase leaves step 5 only toward step 0 or halt.
- The program counter stays still outside step 5.
- Halt is sticky and holds the counter.
- The counter increments by one after arithmetic and unknown opcodes.
- A taken equal-jump lands on its target.

Only the bench's programs can show the data memory contents. That covers add and subtract results with wraparound, an untaken jump, unknown opcodes leaving memory untouched, and seeded random programs compared against a software model of the instruction set.

// File: rtl/m2m_pkg.sv
package m2m_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_LSB = 24;
  localparam int SRC_LSB = 16;
  localparam int DST_LSB = 8;
  localparam int TGT_LSB = 0;

  localparam logic [7:0] OPC_HALT = 8'h00;
  localparam logic [7:0] OPC_ADD  = 8'h7A;
  localparam logic [7:0] OPC_SUB  = 8'h7B;
  localparam logic [7:0] OPC_BEQ  = 8'h7C;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_OPRD   = 3'd2,
    PH_EXEC   = 3'd3,
    PH_STORE  = 3'd4,
    PH_NEXT   = 3'd5,
    PH_HALT   = 3'd6
  } phase_e;

  typedef enum logic [2:0] {
    K_NOP, K_ADD, K_SUB, K_BEQ, K_HALT
  } kind_e;
endpackage

// File: rtl/m2m_ram.sv
module m2m_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/m2m_decode.sv
module m2m_decode
  import m2m_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_e      kind
);
  always_comb begin
    unique case (opcode)
      OPC_HALT: kind = K_HALT;
      OPC_ADD:  kind = K_ADD;
      OPC_SUB:  kind = K_SUB;
      OPC_BEQ:  kind = K_BEQ;
      default:  kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/m2m_alu.sv
module m2m_alu
  import m2m_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_e         kind,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y,
  output logic          eq
);
  always_comb begin
    y  = (kind == K_SUB) ? (a - b) : (a + b);
    eq = (a == b);
  end
endmodule

// File: rtl/m2m_core.sv
module m2m_core
  import m2m_pkg::*;
#(
  parameter int DAW     = 8,
  parameter int IAW     = 8,
  parameter int DW      = 8,
  parameter int BOOT_PC = 0,
  localparam int LAW    = (IAW > DAW) ? IAW : DAW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic               ld_imem,
  input  logic [LAW-1:0]     ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  input  logic [DAW-1:0]     peek_addr,
  output logic [DW-1:0]      peek_data,
  output logic [IAW-1:0]     pc_o,
  output logic [2:0]         phase_o,
  output logic               done
);
  localparam logic [IAW-1:0] PC0     = IAW'(BOOT_PC);
  localparam logic [IAW-1:0] PC_STEP = {{(IAW-1){1'b0}}, 1'b1};
  localparam int             NCOPY   = 2;

  phase_e               phase_q;
  logic [IAW-1:0]       pc_q;
  logic                 done_q;
  kind_e                kind_d, kind_q;
  logic [INSTR_W-1:0]   ir;
  logic [DAW-1:0]       src_a, dst_b;
  logic [IAW-1:0]       tgt;
  logic [DW-1:0]        opa_q, opb_q, res_q, alu_y;
  logic                 alu_eq, eq_q;
  logic [NCOPY-1:0][DW-1:0] dq;

  // instruction memory: its read register doubles as the instruction register
  m2m_ram #(.AW(IAW), .DW(INSTR_W)) u_imem (
    .clk     (clk),
    .wr_en   (ld_en & ld_imem),
    .wr_addr (ld_addr[IAW-1:0]),
    .wr_data (ld_data),
    .rd_en   (phase_q == PH_FETCH),
    .rd_addr (pc_q),
    .rd_data (ir)
  );

  assign src_a = ir[SRC_LSB +: DAW];
  assign dst_b = ir[DST_LSB +: DAW];
  assign tgt   = ir[TGT_LSB +: IAW];

  m2m_decode u_dec (
    .opcode (ir[OPC_LSB +: 8]),
    .kind   (kind_d)
  );

  // data memory write: load port has priority, core writes in the store step
  logic           host_dwe, core_we, dwe;
  logic [DAW-1:0] dwaddr;
  logic [DW-1:0]  dwdata;

  assign host_dwe = ld_en & ~ld_imem;
  assign core_we  = (phase_q == PH_STORE) && (kind_q == K_ADD || kind_q == K_SUB);
  assign dwe      = host_dwe | core_we;
  assign dwaddr   = host_dwe ? ld_addr[DAW-1:0] : dst_b;
  assign dwdata   = host_dwe ? ld_data[DW-1:0]  : res_q;

  // two identical copies give two operand reads per cycle
  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    logic [DAW-1:0] ra;
    if (g == 0) begin : g_first
      assign ra = done_q ? peek_addr : src_a;
    end else begin : g_second
      assign ra = dst_b;
    end
    m2m_ram #(.AW(DAW), .DW(DW)) u_dmem (
      .clk     (clk),
      .wr_en   (dwe),
      .wr_addr (dwaddr),
      .wr_data (dwdata),
      .rd_en   ((phase_q == PH_DECODE) | done_q),
      .rd_addr (ra),
      .rd_data (dq[g])
    );
  end

  m2m_alu #(.W(DW)) u_alu (
    .kind (kind_q),
    .a    (opa_q),
    .b    (opb_q),
    .y    (alu_y),
    .eq   (alu_eq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      pc_q    <= PC0;
      done_q  <= 1'b0;
      kind_q  <= K_NOP;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
      eq_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: begin
          kind_q  <= kind_d;
          phase_q <= PH_OPRD;
        end
        PH_OPRD: begin
          opa_q   <= dq[0];
          opb_q   <= dq[1];
          phase_q <= PH_EXEC;
        end
        PH_EXEC: begin
          res_q   <= alu_y;
          eq_q    <= alu_eq;
          phase_q <= PH_STORE;
        end
        PH_STORE:  phase_q <= PH_NEXT;
        PH_NEXT: begin
          if (kind_q == K_HALT) begin
            done_q  <= 1'b1;
            phase_q <= PH_HALT;
          end else begin
            pc_q    <= (kind_q == K_BEQ && eq_q) ? tgt : pc_q + PC_STEP;
            phase_q <= PH_FETCH;
          end
        end
        PH_HALT:   phase_q <= PH_HALT;
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign phase_o   = phase_q;
  assign done      = done_q;
  assign peek_data = dq[0];

  // R2: leaving the update step goes to the next fetch or to halt
  p_next_phase_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NEXT) |=> (phase_q == PH_FETCH || phase_q == PH_HALT));

  // R6: counter only moves at the end of the update step
  p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_NEXT) |=> $stable(pc_q));

  // R6: sequential advance for arithmetic and unknown opcodes
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NEXT && (kind_q == K_ADD || kind_q == K_SUB || kind_q == K_NOP))
    |=> (pc_q == $past(pc_q) + PC_STEP));

  // R5: a taken jump lands on the target field
  p_beq_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_NEXT && kind_q == K_BEQ && eq_q) |=> (pc_q == $past(tgt)));

  // R8: halt is sticky and freezes the counter
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> (done_q && $stable(pc_q) && phase_q == PH_HALT));
endmodule

// File: tb/m2m_core_bench.sv
module m2m_core_bench;
  localparam int DAW = 8;
  localparam int IAW = 8;
  localparam int DW  = 8;
  localparam int LAW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_en = 1'b0;
  logic           ld_imem = 1'b0;
  logic [LAW-1:0] ld_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [DAW-1:0] peek_addr = '0;
  logic [DW-1:0]  peek_data;
  logic [IAW-1:0] pc_o;
  logic [2:0]     phase_o;
  logic           done;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_d [256];
  logic [31:0] m_i [256];

  always #10 clk = ~clk;

  m2m_core u_m2m_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .pc_o(pc_o), .phase_o(phase_o), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit imem, input int a, input logic [31:0] d);
    ld_en = 1'b1; ld_imem = imem; ld_addr = a[7:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put_d(input int a, input int v);
    m_d[a] = v[7:0];
    wr(1'b0, a, {24'h0, v[7:0]});
  endtask

  task automatic put_i(input int a, input logic [31:0] w);
    m_i[a] = w;
    wr(1'b1, a, w);
  endtask

  task automatic run_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " finish"}, int'(done), 1);
  endtask

  task automatic peek(input int a, output int v);
    peek_addr = a[7:0];
    @(negedge clk);
    @(negedge clk);
    v = int'(peek_data);
  endtask

  function automatic int model_run();
    int pc = 0;
    for (int s = 0; s < 200; s++) begin
      logic [31:0] w = m_i[pc];
      logic [7:0] op = w[31:24];
      logic [7:0] a = w[23:16];
      logic [7:0] b = w[15:8];
      if (op == 8'h00) return pc;
      if (op == 8'h7A) m_d[b] = m_d[a] + m_d[b];
      else if (op == 8'h7B) m_d[b] = m_d[a] - m_d[b];
      if (op == 8'h7C && m_d[a] == m_d[b]) pc = int'(w[7:0]);
      else pc = (pc + 1) % 256;
    end
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", int'(pc_o), 0);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 done", int'(done), 0);

    // directed: jump to 0x50, add, halt (R9 load path, R3 layout)
    put_d(8'h00, 9); put_d(8'hF0, 2); put_d(8'h10, 5);
    put_i(8'h00, 32'h7C000050);
    put_i(8'h50, 32'h7AF01000);
    put_i(8'h51, 32'h00000000);
    rst = 1'b0;
    for (int k = 0; k < 7; k++) begin
      chk("R2 phase sequence", int'(phase_o), k % 6);
      chk("R6 pc timing / R5 taken", int'(pc_o), (k < 6) ? 0 : 8'h50);
      @(negedge clk);
    end
    run_done("R8");
    chk("R6 pc after add", int'(pc_o), 8'h51);
    chk("R8 halt phase", int'(phase_o), 6);
    peek(8'h10, v); chk("R3 add result", v, 8'h07);
    peek(8'hF0, v); chk("R10 peek source", v, 8'h02);
    repeat (20) @(negedge clk);
    chk("R8 pc frozen", int'(pc_o), 8'h51);
    chk("R8 done held", int'(done), 1);

    // directed: subtract wrap, untaken jump, unknown opcode, add wrap
    rst = 1'b1;
    put_d(8'h20, 3); put_d(8'h21, 5);
    put_d(8'h30, 4); put_d(8'h31, 6);
    put_d(8'h40, 8'h11); put_d(8'h41, 8'h22);
    put_d(8'h50, 8'h80); put_d(8'h51, 8'h90);
    put_i(0, 32'h7B2021FF);
    put_i(1, 32'h7C303160);
    put_i(2, 32'h554041AA);
    put_i(3, 32'h7A505133);
    put_i(4, 32'h00000000);
    rst = 1'b0;
    run_done("R4");
    chk("R5 untaken / R6 end pc", int'(pc_o), 4);
    peek(8'h21, v); chk("R4 sub wrap", v, 8'hFE);
    peek(8'h20, v); chk("R4 first operand kept", v, 3);
    peek(8'h31, v); chk("R5 no write", v, 6);
    peek(8'h40, v); chk("R7 unknown first", v, 8'h11);
    peek(8'h41, v); chk("R7 unknown second", v, 8'h22);
    peek(8'h51, v); chk("R3 add wrap", v, 8'h10);

    // constrained random programs against the bench model
    for (int p = 0; p < 25; p++) begin
      int exp_pc;
      rst = 1'b1;
      for (int a = 0; a < 16; a++) put_d(a, $urandom % 4);
      for (int i = 0; i < 10; i++) begin
        int r = $urandom % 4;
        logic [7:0] op, t;
        logic [7:0] sa = 8'($urandom % 16);
        logic [7:0] sb = 8'($urandom % 16);
        t = 8'($urandom % 256);
        case (r)
          0: op = 8'h7A;
          1: op = 8'h7B;
          2: begin op = 8'h7C; t = 8'(i + 1 + ($urandom % (10 - i))); end
          default: op = 8'(1 + ($urandom % 8'h70));
        endcase
        put_i(i, {op, sa, sb, t});
      end
      put_i(10, 32'h0);
      rst = 1'b0;
      exp_pc = model_run();
      run_done("R6 random");
      chk("R5/R6 random end pc", int'(pc_o), exp_pc);
      for (int a = 0; a < 16; a++) begin
        peek(a, v);
        chk("R3/R4/R7 random data", v, int'(m_d[a]));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule